// File: doc/BRIEF.md
# Board-side hot-swap power sequencer

This block is the control logic on a hot-swappable plug-in card. The backplane sends an active-low board-select request. The block turns that request into a power-enable for an external power switch. It also combines three signals into an active-low health indication: the switch's fault flag, its own enable state and the output rail's power-good. The health indication gates the local bus reset. The local reset can be released only while the card is healthy and the system bus reset is released. When health is lost, the local reset is forced active through a purely combinational path.

The block also handles extraction. When the ejector handle opens, the card drives its open-drain enumeration line low to announce that removal is coming. This output is modelled as an output-enable. Once the system answers by asserting the bus reset, a ready-to-remove LED lights. Closing the handle again withdraws both. Board-select and the handle switch pass through a synchronizer and a debounce filter before use. The fault, power-good and system-reset inputs pass through the synchronizer only.

Top module: `hs_pwr_seq`

## Requirements
- R1: While rst_n is low: pwr_en_o=0, healthy_n_o=1, local_rst_n_o=0, enum_oe_o=0 and led_o=0.
- R2: pwr_en_o is the inverse of the filtered board-select. Power stays off for as long as bsel_n_i is held high, however long that is.
- R3: healthy_n_o is 0 exactly when sw_fault_n_i=1 (no fault), pwr_en_o=1 and rail_pg_i=1, all three together. Otherwise it is 1.
- R4: local_rst_n_o is 1 only while healthy_n_o=0 and sys_rst_n_i=1. Otherwise it is 0.
- R5: local_rst_n_o reacts to sys_rst_n_i and to loss of health with no clock edge in between.
- R6: A level change on bsel_n_i or handle_open_i takes effect only after it has been stable for 2^DB_CNT_W clock cycles. Shorter pulses are ignored.
- R7: An accepted opening of the handle (handle_open_i=1) sets enum_oe_o=1.
- R8: led_o turns on only after enum_oe_o is already set and the system has then asserted its bus reset (sys_rst_n_i=0).
- R9: An accepted closing of the handle (handle_open_i=0) clears enum_oe_o and led_o.
- R10: When bsel_n_i goes high, pwr_en_o drops and healthy_n_o returns to 1. It stays at 1 while rail_pg_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bsel_n_i | input | 1 | Board-select from backplane, active low, pulled high on card |
| handle_open_i | input | 1 | Ejector handle switch, 1 = open |
| sw_fault_n_i | input | 1 | Power switch fault flag, 0 = fault |
| rail_pg_i | input | 1 | Output rail power-good |
| sys_rst_n_i | input | 1 | System bus reset, active low |
| pwr_en_o | output | 1 | Enable to the external power switch |
| healthy_n_o | output | 1 | Active-low card health |
| local_rst_n_o | output | 1 | Gated local bus reset, active low |
| enum_oe_o | output | 1 | Drive-low enable of open-drain enumeration line |
| led_o | output | 1 | Ready-to-remove indicator |

## Verification
The bench targets several corner cases, and each has a distinct failure signature. The first is a board-select pulse shorter than the debounce window. A design without filtering would switch power on briefly. The second is the health qualification with exactly one of its three terms missing. An OR-style or partial combination would report a healthy card with a rail that is not good or with a latched fault. The bench toggles the system reset between clock edges and samples a fraction of a nanosecond later. A registered local-reset path would still show the old level at that point. The extraction order is checked in both directions: the LED must stay dark until the bus reset follows the enumeration request, and closing the handle must clear both. A design that lit the LED on the handle alone, or kept its state after closing, would fail these checks.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        EJ_SEATED  = 2'd0,
        EJ_REQUEST = 2'd1,
        EJ_READY   = 2'd2
    } ej_state_e;

    typedef struct packed {
        logic      pwr_en;
        ej_state_e ej;
    } seq_state_t;

    // bit positions in the synchronized input vector
    localparam int IDX_BSEL   = 0;
    localparam int IDX_HANDLE = 1;
    localparam int IDX_FAULT  = 2;
    localparam int IDX_PG     = 3;
    localparam int IDX_SYSRST = 4;
    localparam int N_IN       = 5;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hs_debounce.sv
module hs_debounce #(
    parameter int   CNT_W   = 16,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level
);
    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
    } db_t;

    db_t db_d, db_q;

    always_comb begin
        db_d = db_q;
        if (din != db_q.level) begin
            if (&db_q.cnt) begin
                db_d.level = din;
                db_d.cnt   = '0;
            end else begin
                db_d.cnt = db_q.cnt + 1'b1;
            end
        end else begin
            db_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            db_q.level <= RST_VAL;
            db_q.cnt   <= '0;
        end else begin
            db_q <= db_d;
        end
    end

    assign level = db_q.level;
endmodule

// File: rtl/hs_pwr_seq.sv
module hs_pwr_seq
    import hs_pkg::*;
#(
    parameter int DB_CNT_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsel_n_i,
    input  logic handle_open_i,
    input  logic sw_fault_n_i,
    input  logic rail_pg_i,
    input  logic sys_rst_n_i,
    output logic pwr_en_o,
    output logic healthy_n_o,
    output logic local_rst_n_o,
    output logic enum_oe_o,
    output logic led_o
);
    // reset levels: board deselected, handle closed, fault assumed, rail down, bus in reset
    localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << IDX_BSEL;
    localparam int              N_DB     = 2;
    localparam logic [N_DB-1:0] DB_RST   = 2'b01;

    logic [N_IN-1:0] raw_v, sync_v;
    logic [N_DB-1:0] db_v;

    assign raw_v[IDX_BSEL]   = bsel_n_i;
    assign raw_v[IDX_HANDLE] = handle_open_i;
    assign raw_v[IDX_FAULT]  = sw_fault_n_i;
    assign raw_v[IDX_PG]     = rail_pg_i;
    assign raw_v[IDX_SYSRST] = sys_rst_n_i;

    hs_sync #(
        .W       (N_IN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_v),
        .dout  (sync_v)
    );

    // debounce filters for the two mechanical / backplane select inputs
    for (genvar g = 0; g < N_DB; g++) begin : g_db
        hs_debounce #(
            .CNT_W   (DB_CNT_W),
            .RST_VAL (DB_RST[g])
        ) u_db (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (sync_v[g]),
            .level (db_v[g])
        );
    end

    logic bsel_db, handle_db, fault_n_s, pg_s, sysrst_n_s, healthy;
    assign bsel_db    = db_v[IDX_BSEL];
    assign handle_db  = db_v[IDX_HANDLE];
    assign fault_n_s  = sync_v[IDX_FAULT];
    assign pg_s       = sync_v[IDX_PG];
    assign sysrst_n_s = sync_v[IDX_SYSRST];

    seq_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.pwr_en = ~bsel_db;
        unique case (st_q.ej)
            EJ_SEATED:  if (handle_db) st_d.ej = EJ_REQUEST;
            EJ_REQUEST: begin
                if (!handle_db)       st_d.ej = EJ_SEATED;
                else if (!sysrst_n_s) st_d.ej = EJ_READY;
            end
            EJ_READY:   if (!handle_db) st_d.ej = EJ_SEATED;
            default:    st_d.ej = EJ_SEATED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pwr_en <= 1'b0;
            st_q.ej     <= EJ_SEATED;
        end else begin
            st_q <= st_d;
        end
    end

    // health and local reset: no register after the qualification terms
    assign healthy       = fault_n_s & st_q.pwr_en & pg_s;
    assign healthy_n_o   = ~healthy;
    assign local_rst_n_o = sys_rst_n_i & healthy;
    assign pwr_en_o      = st_q.pwr_en;
    assign enum_oe_o     = (st_q.ej != EJ_SEATED);
    assign led_o         = (st_q.ej == EJ_READY);
endmodule

// File: rtl/hs_pwr_seq_chk.sv
module hs_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sys_rst_n_i,
    input logic pwr_en_o,
    input logic healthy_n_o,
    input logic local_rst_n_o,
    input logic enum_oe_o,
    input logic led_o
);
    AST_HEALTHY_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        !healthy_n_o |-> pwr_en_o); // R3

    AST_LOCAL_NEEDS_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_n_o |-> !healthy_n_o); // R4

    AST_LOCAL_NEEDS_SYSRST: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_n_o |-> sys_rst_n_i); // R5

    AST_LED_AFTER_ENUM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_o) |-> $past(enum_oe_o)); // R8

    AST_LED_NEEDS_ENUM: assert property (@(posedge clk) disable iff (!rst_n)
        led_o |-> enum_oe_o); // R9
endmodule

bind hs_pwr_seq hs_pwr_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sys_rst_n_i   (sys_rst_n_i),
    .pwr_en_o      (pwr_en_o),
    .healthy_n_o   (healthy_n_o),
    .local_rst_n_o (local_rst_n_o),
    .enum_oe_o     (enum_oe_o),
    .led_o         (led_o)
);

// File: tb/hs_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module hs_pwr_seq_tb_top;
    localparam int DBW = 3;   // 8-cycle debounce window for the bench
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst_n, bsel_n, handle_open, fault_n, pg, sys_rst_n;
    logic pwr_en, healthy_n, local_rst_n, enum_oe, led;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hs_pwr_seq #(.DB_CNT_W(DBW), .SYNC_STAGES(2)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bsel_n_i      (bsel_n),
        .handle_open_i (handle_open),
        .sw_fault_n_i  (fault_n),
        .rail_pg_i     (pg),
        .sys_rst_n_i   (sys_rst_n),
        .pwr_en_o      (pwr_en),
        .healthy_n_o   (healthy_n),
        .local_rst_n_o (local_rst_n),
        .enum_oe_o     (enum_oe),
        .led_o         (led)
    );

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 0; bsel_n = 1; handle_open = 0; fault_n = 1; pg = 0; sys_rst_n = 0;
        cyc(5);
        check("R1", "pwr_en",   pwr_en,      1'b0);
        check("R1", "healthy_n", healthy_n,  1'b1);
        check("R1", "local_rst", local_rst_n, 1'b0);
        check("R1", "enum_oe",  enum_oe,     1'b0);
        check("R1", "led",      led,         1'b0);
        rst_n = 1;
        cyc(2);
    endtask

    task automatic t_holdoff;
        pg = 1;
        cyc(60);
        check("R2", "pwr held off", pwr_en, 1'b0);
        check("R3", "healthy without pwr", healthy_n, 1'b1);
        pg = 0;
        cyc(4);
    endtask

    task automatic t_glitch;
        bsel_n = 0; cyc(4); bsel_n = 1;
        cyc(SETTLE);
        check("R6", "short bsel pulse", pwr_en, 1'b0);
        handle_open = 1; cyc(4); handle_open = 0;
        cyc(SETTLE);
        check("R6", "short handle pulse", enum_oe, 1'b0);
    endtask

    task automatic t_power_up;
        bsel_n = 0;
        cyc(SETTLE);
        check("R2", "pwr after select", pwr_en, 1'b1);
        check("R3", "healthy without pg", healthy_n, 1'b1);
        pg = 1; cyc(5);
        check("R3", "all three good", healthy_n, 1'b0);
        fault_n = 0; cyc(5);
        check("R3", "fault present", healthy_n, 1'b1);
        fault_n = 1; cyc(5);
        check("R3", "fault cleared", healthy_n, 1'b0);
    endtask

    task automatic t_local_reset;
        check("R4", "sys reset held", local_rst_n, 1'b0);
        sys_rst_n = 1; #0.5;
        check("R4", "released with healthy", local_rst_n, 1'b1);
        sys_rst_n = 0; #0.5;
        check("R5", "comb follow sys reset", local_rst_n, 1'b0);
        sys_rst_n = 1;
        cyc(2);
        pg = 0; cyc(5);
        check("R5", "health loss forces reset", local_rst_n, 1'b0);
        check("R4", "unhealthy", healthy_n, 1'b1);
        pg = 1; cyc(5);
        check("R4", "healthy again", local_rst_n, 1'b1);
    endtask

    task automatic t_extraction;
        handle_open = 1;
        cyc(SETTLE);
        check("R7", "enum on handle open", enum_oe, 1'b1);
        check("R8", "led before bus reset", led, 1'b0);
        sys_rst_n = 0; cyc(5);
        check("R8", "led after bus reset", led, 1'b1);
        check("R4", "local in reset", local_rst_n, 1'b0);
    endtask

    task automatic t_handle_close;
        handle_open = 0;
        cyc(SETTLE);
        check("R9", "enum cleared", enum_oe, 1'b0);
        check("R9", "led cleared", led, 1'b0);
        cyc(10);
        check("R8", "led stays off without request", led, 1'b0);
    endtask

    task automatic t_power_down;
        bsel_n = 1;
        cyc(SETTLE);
        check("R10", "pwr dropped", pwr_en, 1'b0);
        check("R10", "healthy high", healthy_n, 1'b1);
        pg = 0; cyc(5);
        check("R10", "healthy high after pg fall", healthy_n, 1'b1);
    endtask

    initial begin
        t_reset;
        t_holdoff;
        t_glitch;
        t_power_up;
        t_local_reset;
        t_extraction;
        t_handle_close;
        t_power_down;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule